// File: doc/BRIEF.md
# Write Mirror Range Filter

This block sits between a fast processor and a slower shared system memory. Every processor write lands in fast local RAM. The write only has to be repeated into the slow RAM when a video fetcher might read that address. A two-bit optimization mode picks which address window counts as visible to video. Writes that fall inside the selected window have their addresses queued in a small FIFO. A copy engine then drains the FIFO through a ready/valid port. Writes outside the window are accepted and produce no copy request.

The mode is held in a register that reset sets to "mirror everything". It is loaded through a strobe. A new mode applies to writes presented after the strobe cycle. Entries that are already queued stay in the FIFO. When the FIFO is full, the processor side is stalled through a ready signal, so no copy request is ever lost.

Top module: `wr_mirror_filter`

## Requirements
- R1: After reset, and again after any later reset, mir_valid is 0, cpu_wr_ready is 1, the FIFO is empty and the mode is 2'b11 (mirror all).
- R2: In mode 2'b11, every accepted write (cpu_wr_valid and cpu_wr_ready both high at a rising edge) queues its address.
- R3: In mode 2'b00, an accepted write queues its address only if it lies in 0x8000 to 0xBFFF inclusive.
- R4: In mode 2'b01, an accepted write queues its address only if it lies in 0x4000 to 0x7FFF inclusive.
- R5: In mode 2'b10, an accepted write queues its address only if it lies in 0x0400 to 0x07FF inclusive.
- R6: A mode_wr pulse loads mode_in at that edge. A write accepted in the same cycle uses the old mode, and writes accepted in later cycles use the new mode. Entries already queued are kept.
- R7: Queued addresses appear on mir_addr in write order. Each one is offered while mir_valid is high and is removed on a cycle where mir_valid and mir_ready are both high. While mir_valid is high and mir_ready is low, mir_addr holds steady.
- R8: cpu_wr_ready is low exactly when DEPTH entries are pending. A write presented while it is low is not accepted and queues nothing. An empty FIFO always reports ready.
- R9: A queued address becomes visible on mir_valid/mir_addr one clock after the accepting edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously by the system |
| mode_wr | input | 1 | Load strobe for the mode register |
| mode_in | input | 2 | New mode: 00 upper bank, 01 second bank, 10 text screen, 11 all |
| cpu_wr_valid | input | 1 | Processor write strobe |
| cpu_wr_addr | input | 16 | Processor write address |
| cpu_wr_ready | output | 1 | High when a write can be accepted |
| mir_valid | output | 1 | A mirror address is pending |
| mir_addr | output | 16 | Oldest pending mirror address |
| mir_ready | input | 1 | Copy engine takes the offered address |

## Verification
The assertions assume two things about the environment. First, a copy engine keeps mir_ready meaningful only while it is sampled at clock edges. Second, reset is held for at least one edge before traffic starts, so the mode register and the FIFO count begin from known values. The bench drives every input half a cycle away from the sampling edge. It asserts reset before any write, and it pulses mode_wr only as single-cycle strobes. Its reference model steps the FIFO and the mode in the same order the requirements state: the write is judged by the old mode, then the mode is loaded.

// File: rtl/wmf_pkg.sv
package wmf_pkg;
  localparam int ADDR_W = 16;

  typedef enum logic [1:0] {
    MODE_UPPER = 2'b00,
    MODE_BANK1 = 2'b01,
    MODE_TEXT  = 2'b10,
    MODE_ALL   = 2'b11
  } mir_mode_e;

  localparam mir_mode_e RESET_MODE = MODE_ALL;
endpackage

// File: rtl/wmf_mode_reg.sv
module wmf_mode_reg
  import wmf_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       load,
  input  logic [1:0] value,
  output mir_mode_e  mode
);
  mir_mode_e mode_d;
  mir_mode_e mode_q;

  always_comb begin
    mode_d = mode_q;
    if (load) mode_d = mir_mode_e'(value);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    mode_q <= RESET_MODE;
    else if (load) mode_q <= mode_d;
  end

  assign mode = mode_q;
endmodule

// File: rtl/wmf_window_dec.sv
module wmf_window_dec
  import wmf_pkg::*;
(
  input  mir_mode_e         mode,
  input  logic [ADDR_W-1:0] addr,
  output logic              hit
);
  localparam int TOP = ADDR_W - 1;

  always_comb begin
    unique case (mode)
      MODE_UPPER: hit = (addr[TOP -: 2] == 2'b10);
      MODE_BANK1: hit = (addr[TOP -: 2] == 2'b01);
      MODE_TEXT:  hit = (addr[TOP -: 6] == 6'b000001);
      default:    hit = 1'b1;
    endcase
  end
endmodule

// File: rtl/wmf_fifo.sv
module wmf_fifo #(
  parameter int WIDTH = 16,
  parameter int DEPTH = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic [WIDTH-1:0] push_data,
  input  logic             pop,
  output logic [WIDTH-1:0] head,
  output logic             not_empty,
  output logic             full
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [PTR_W-1:0] wr_q, wr_d, rd_q, rd_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             do_push, do_pop;

  assign do_push = push && (cnt_q != FULL_CNT);
  assign do_pop  = pop && (cnt_q != '0);

  always_comb begin
    wr_d  = wr_q;
    rd_d  = rd_q;
    cnt_d = cnt_q;
    if (do_push) wr_d = (wr_q == LAST) ? '0 : wr_q + 1'b1;
    if (do_pop)  rd_d = (rd_q == LAST) ? '0 : rd_q + 1'b1;
    if (do_push && !do_pop)      cnt_d = cnt_q + 1'b1;
    else if (do_pop && !do_push) cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      wr_q  <= wr_d;
      rd_q  <= rd_d;
      cnt_q <= cnt_d;
    end
  end

  generate
    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
      always_ff @(posedge clk) begin
        if (do_push && wr_q == PTR_W'(i)) mem[i] <= push_data;
      end
    end
  endgenerate

  assign head      = mem[rd_q];
  assign not_empty = (cnt_q != '0);
  assign full      = (cnt_q == FULL_CNT);
endmodule

// File: rtl/wr_mirror_filter.sv
module wr_mirror_filter
  import wmf_pkg::*;
#(
  parameter int DEPTH = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        mode_wr,
  input  logic [1:0]  mode_in,
  input  logic        cpu_wr_valid,
  input  logic [15:0] cpu_wr_addr,
  output logic        cpu_wr_ready,
  output logic        mir_valid,
  output logic [15:0] mir_addr,
  input  logic        mir_ready
);
  mir_mode_e mode_q;
  logic      in_window;
  logic      accept;
  logic      fifo_full;

  wmf_mode_reg u_mode (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (mode_wr),
    .value (mode_in),
    .mode  (mode_q)
  );

  wmf_window_dec u_dec (
    .mode (mode_q),
    .addr (cpu_wr_addr),
    .hit  (in_window)
  );

  assign cpu_wr_ready = !fifo_full;
  assign accept       = cpu_wr_valid && cpu_wr_ready;

  wmf_fifo #(.WIDTH(ADDR_W), .DEPTH(DEPTH)) u_fifo (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (accept && in_window),
    .push_data (cpu_wr_addr),
    .pop       (mir_ready),
    .head      (mir_addr),
    .not_empty (mir_valid),
    .full      (fifo_full)
  );
endmodule

// File: rtl/wmf_checker.sv
module wmf_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        mode_wr,
  input logic [1:0]  mode_in,
  input logic [1:0]  mode_q,
  input logic        cpu_wr_valid,
  input logic [15:0] cpu_wr_addr,
  input logic        cpu_wr_ready,
  input logic        mir_valid,
  input logic [15:0] mir_addr,
  input logic        mir_ready
);
  assert_all_mode_queues_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == 2'b11 && cpu_wr_valid && cpu_wr_ready) |=> mir_valid);

  assert_upper_outside_skipped_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == 2'b00 && cpu_wr_valid && cpu_wr_ready && !mir_valid &&
     (cpu_wr_addr < 16'h8000 || cpu_wr_addr > 16'hBFFF)) |=> !mir_valid);

  assert_mode_load_R6: assert property (@(posedge clk) disable iff (!rst_n)
    mode_wr |=> (mode_q == $past(mode_in)));

  assert_head_held_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (mir_valid && !mir_ready) |=> (mir_valid && $stable(mir_addr)));

  assert_empty_ready_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !mir_valid |-> cpu_wr_ready);
endmodule

bind wr_mirror_filter wmf_checker chk_i (
  .clk          (clk),
  .rst_n        (rst_n),
  .mode_wr      (mode_wr),
  .mode_in      (mode_in),
  .mode_q       (mode_q),
  .cpu_wr_valid (cpu_wr_valid),
  .cpu_wr_addr  (cpu_wr_addr),
  .cpu_wr_ready (cpu_wr_ready),
  .mir_valid    (mir_valid),
  .mir_addr     (mir_addr),
  .mir_ready    (mir_ready)
);

// File: tb/wr_mirror_filter_tb_top.sv
module wr_mirror_filter_tb_top;
  localparam int DEPTH = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        mode_wr = 1'b0;
  logic [1:0]  mode_in = 2'b00;
  logic        cpu_wr_valid = 1'b0;
  logic [15:0] cpu_wr_addr = '0;
  logic        cpu_wr_ready;
  logic        mir_valid;
  logic [15:0] mir_addr;
  logic        mir_ready = 1'b0;

  always #4 clk = ~clk;

  wr_mirror_filter #(.DEPTH(DEPTH)) dut_i (.*);

  int n_checks = 0;
  int n_fail   = 0;
  string tag = "R1";
  logic [15:0] q[$];
  logic [1:0]  m_mode = 2'b11;

  function automatic bit in_win(logic [1:0] m, logic [15:0] a);
    case (m)
      2'b00:   return a >= 16'h8000 && a <= 16'hBFFF;
      2'b01:   return a >= 16'h4000 && a <= 16'h7FFF;
      2'b10:   return a >= 16'h0400 && a <= 16'h07FF;
      default: return 1'b1;
    endcase
  endfunction

  task automatic check(string req, string what, int act, int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic compare();
    check(tag, "mir_valid", int'(mir_valid), int'(q.size() > 0));
    check("R8", "cpu_wr_ready", int'(cpu_wr_ready), int'(q.size() < DEPTH));
    if (q.size() > 0) check("R7", "mir_addr", int'(mir_addr), int'(q[0]));
  endtask

  // one clock: inputs applied now, model advanced with them, outputs compared
  task automatic step(bit v, logic [15:0] a, bit mw, logic [1:0] mi, bit rdy);
    bit rdy_m, acc;
    cpu_wr_valid = v; cpu_wr_addr = a; mode_wr = mw; mode_in = mi; mir_ready = rdy;
    @(negedge clk);
    rdy_m = q.size() < DEPTH;
    acc   = v && rdy_m;
    if (q.size() > 0 && rdy) void'(q.pop_front());
    if (acc && in_win(m_mode, a)) q.push_back(a);
    if (mw) m_mode = mi;
    compare();
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    q.delete();
    m_mode = 2'b11;
    step(0, 16'h0, 0, 2'b00, 0);
    tag = "R1";
    check("R1", "reset mir_valid", int'(mir_valid), 0);
    check("R1", "reset ready", int'(cpu_wr_ready), 1);
    rst_n = 1'b1;
    step(0, 16'h0, 0, 2'b00, 0);
  endtask

  task automatic set_mode(logic [1:0] m);
    step(0, 16'h0, 1, m, 1);
    step(0, 16'h0, 0, 2'b00, 1);
  endtask

  task automatic sweep(logic [1:0] m, string r, logic [15:0] lo, logic [15:0] hi);
    tag = r;
    set_mode(m);
    step(1, lo - 16'd1, 0, 2'b00, 1);
    step(1, lo,         0, 2'b00, 1);
    step(1, hi,         0, 2'b00, 1);
    step(1, hi + 16'd1, 0, 2'b00, 1);
    for (int i = 0; i < 40; i++)
      step(1, 16'($urandom), 0, 2'b00, $urandom_range(0, 1) == 1);
    for (int i = 0; i < 8; i++) step(0, 16'h0, 0, 2'b00, 1);
  endtask

  initial begin
    fork
      begin
        repeat (100000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
      end
    join_none

    // R1: reset state, mirror-all afterwards
    do_reset();
    tag = "R1";
    step(1, 16'h1234, 0, 2'b00, 0);
    check("R1", "mirror-all after reset", int'(mir_valid), 1);
    step(0, 16'h0, 0, 2'b00, 1);
    step(0, 16'h0, 0, 2'b00, 1);

    // R2: all addresses, random drain
    tag = "R2";
    for (int i = 0; i < 60; i++)
      step($urandom_range(0, 1) == 1, 16'($urandom), 0, 2'b00, $urandom_range(0, 2) != 0);
    for (int i = 0; i < 8; i++) step(0, 16'h0, 0, 2'b00, 1);

    sweep(2'b00, "R3", 16'h8000, 16'hBFFF);
    sweep(2'b01, "R4", 16'h4000, 16'h7FFF);
    sweep(2'b10, "R5", 16'h0400, 16'h07FF);

    // R6: same-cycle write uses old mode (text), pending kept across change
    tag = "R6";
    step(1, 16'h0500, 0, 2'b00, 0);
    step(1, 16'h9000, 1, 2'b00, 0);
    check("R6", "same-cycle write used old mode", q.size(), 1);
    step(1, 16'h9000, 0, 2'b00, 0);
    check("R6", "new mode applied next write", int'(mir_addr), 16'h0500);
    step(0, 16'h0, 0, 2'b00, 1);
    check("R6", "second entry from new mode", int'(mir_addr), 16'h9000);
    step(0, 16'h0, 0, 2'b00, 1);

    // R8/R9/R7: fill while stalled, extra writes ignored, ordered drain
    tag = "R8";
    set_mode(2'b11);
    step(1, 16'hA001, 0, 2'b00, 0);
    check("R9", "visible one clock after accept", int'(mir_valid), 1);
    for (int i = 2; i <= 6; i++) step(1, 16'hA000 + 16'(i), 0, 2'b00, 0);
    check("R8", "ready low when full", int'(cpu_wr_ready), 0);
    for (int i = 1; i <= DEPTH; i++) begin
      check("R7", "drain order", int'(mir_addr), 16'hA000 + i);
      step(0, 16'h0, 0, 2'b00, 1);
    end
    check("R8", "stalled writes not queued", int'(mir_valid), 0);

    // R1: mid-run reset restores mirror-all and clears pending
    set_mode(2'b10);
    step(1, 16'h0600, 0, 2'b00, 0);
    do_reset();
    check("R1", "reset cleared pending", int'(mir_valid), 0);
    step(1, 16'hF00F, 0, 2'b00, 0);
    check("R1", "mode back to all", int'(mir_valid), 1);
    step(0, 16'h0, 0, 2'b00, 1);
    step(0, 16'h0, 0, 2'b00, 1);

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule